// File: doc/BRIEF.md
# Dual-Unit System Watchdog

This block is a system watchdog. It counts down from a value that software loads, and it fires when the count reaches zero. The count steps on an external one-pulse-per-second tick. A unit bit in the configuration register sets the step to one second or to one minute. In minute mode, a prescaler groups `TICKS_PER_MIN` ticks into one step.

On expiry the block latches a status flag. It can also drive a reset pulse, a power-good drop, or both, for `RST_PULSE` clock cycles. Four peripheral activity strobes can each be enabled to restore the last written count while the watchdog is running: infrared, mouse, keyboard and game port. Software can also force an expiry at once. A count of zero means the watchdog is stopped.

The register port is a plain byte-wide write strobe with a combinational read mux. It has no back-pressure: every write is accepted in the cycle that `bus_we` is high, and a read returns data in the same cycle for the address presented. The counter width `CNT_W` lies between 8 and 16 bits.

Top module: `wdt_top`

## Requirements
- R1: After reset, every mapped register reads 0x00, `sys_rst_o` is low and `pwr_ok_o` is high. The control register is at 0x71, the configuration register at 0x72, count low byte at 0x73 and count high byte at 0x74. Any other address reads 0x00. Configuration reads back all 8 written bits.
- R2: A write to 0x73 loads the count and the reload value with {held high byte, written byte}. A write to 0x74 only holds the high byte, so the count is unchanged until the next 0x73 write. Reads of 0x73/0x74 return the live count's low/high byte. With `CNT_W`=8, writes to 0x74 are ignored and it reads 0x00.
- R3: With configuration bit 7 set (seconds), each `sec_tick` pulse lowers a nonzero count by exactly 1.
- R4: With configuration bit 7 clear (minutes), the count drops by 1 on every `TICKS_PER_MIN`-th tick. The prescaler restarts on every load or reload.
- R5: While the count is 0 the watchdog is stopped: ticks do not change the count, and nothing expires.
- R6: A step from 1 to 0 is an expiry. The count stays at 0 and control bit 0 (status) becomes 1. If configuration bit 6 was set, `sys_rst_o` is high for exactly `RST_PULSE` cycles starting the cycle after the expiry edge; otherwise it stays low.
- R7: If configuration bit 4 is set at expiry, `pwr_ok_o` is low for exactly `RST_PULSE` cycles, with the same timing as R6; otherwise it stays high.
- R8: The control bits enable reload sources: bit 7 infrared (`ir_stb`), bit 6 mouse, bit 5 keyboard and bit 4 game port. An enabled strobe while running restores the last written count. A disabled strobe, or any strobe while stopped, leaves the count unchanged.
- R9: Writing control with bit 1 set forces an expiry at that edge, even when stopped. The count goes to 0, status sets, and the pulses of R6/R7 follow. Bit 1 always reads 0.
- R10: Writing control with bit 0 = 0 clears status. Writing bit 0 = 1 never sets it. An expiry in the same cycle as a clearing write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| sec_tick | input | 1 | One-second tick, one cycle wide |
| ir_stb | input | 1 | Infrared activity strobe |
| mouse_stb | input | 1 | Mouse interrupt strobe |
| kbd_stb | input | 1 | Keyboard interrupt strobe |
| gp_stb | input | 1 | Game-port access strobe |
| sys_rst_o | output | 1 | System reset pulse, active high |
| pwr_ok_o | output | 1 | Power-good, dropped low on expiry when enabled |

## Verification
The assertions assume that `bus_addr`, `bus_we` and the strobes never carry unknown values after reset. They also assume that `sec_tick` is a single-cycle pulse. The pulse-width checks assume that a forced expiry is not repeated while a pulse is still running. The stimulus drives every input on the falling edge, holds each tick, strobe and write for one cycle, and lets each pulse finish before the next expiry. This keeps the run within those limits.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] ADR_CTRL = 8'h71;
  localparam logic [7:0] ADR_CFG  = 8'h72;
  localparam logic [7:0] ADR_CLO  = 8'h73;
  localparam logic [7:0] ADR_CHI  = 8'h74;

  localparam int CB_FORCE = 1;
  localparam int CB_STAT  = 0;
  localparam int CB_EN_LO = 4;   // enables in bits 7..4: ir, mouse, kbd, game

  localparam int FB_SEC = 7;
  localparam int FB_RST = 6;
  localparam int FB_PG  = 4;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [7:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             expire,
  output logic [3:0]       src_en,
  output logic             sec_mode,
  output logic             rst_en,
  output logic             pg_en,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             force_exp,
  output logic             status
);
  localparam int HI_W = CNT_W - 8;

  logic [3:0] en_q;
  logic [7:0] cfg_q;
  logic       stat_q;
  logic [7:0] hi_rd;
  logic       wr_ctrl;

  assign wr_ctrl   = bus_we && (bus_addr == ADR_CTRL);
  assign load      = bus_we && (bus_addr == ADR_CLO);
  assign force_exp = wr_ctrl && bus_wdata[CB_FORCE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      cfg_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= bus_wdata[7:CB_EN_LO];
      if (bus_we && (bus_addr == ADR_CFG)) cfg_q <= bus_wdata;
      if (expire) stat_q <= 1'b1;
      else if (wr_ctrl) stat_q <= stat_q & bus_wdata[CB_STAT];
    end
  end

  generate
    if (HI_W > 0) begin : g_wide
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= '0;
        else if (bus_we && (bus_addr == ADR_CHI)) hi_q <= bus_wdata[HI_W-1:0];
      end
      assign load_val = {hi_q, bus_wdata};
      assign hi_rd    = 8'(cnt[CNT_W-1:8]);
    end else begin : g_narrow
      assign load_val = bus_wdata;
      assign hi_rd    = 8'h00;
    end
  endgenerate

  always_comb begin
    unique case (bus_addr)
      ADR_CTRL: bus_rdata = {en_q, 3'b000, stat_q};
      ADR_CFG:  bus_rdata = cfg_q;
      ADR_CLO:  bus_rdata = cnt[7:0];
      ADR_CHI:  bus_rdata = hi_rd;
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign src_en   = en_q;
  assign sec_mode = cfg_q[FB_SEC];
  assign rst_en   = cfg_q[FB_RST];
  assign pg_en    = cfg_q[FB_PG];
  assign status   = stat_q;
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int TICKS_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sec_mode,
  input  logic restart,
  output logic step
);
  localparam int PW = (TICKS_PER_MIN > 2) ? $clog2(TICKS_PER_MIN) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MIN - 1);

  logic [PW-1:0] pre_q;

  assign step = tick && !restart && (sec_mode || (pre_q == LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pre_q <= '0;
    else if (restart || sec_mode) pre_q <= '0;
    else if (tick)               pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload,
  input  logic             step,
  input  logic             force_exp,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, rl_q;

  assign running = (cnt_q != '0);
  assign expire  = force_exp ||
                   (running && step && !load && !reload && (cnt_q == CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rl_q  <= '0;
    end else begin
      if (load) rl_q <= load_val;
      if (force_exp)               cnt_q <= '0;
      else if (load)               cnt_q <= load_val;
      else if (reload && running)  cnt_q <= rl_q;
      else if (step && running)    cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int RST_PULSE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic rst_en,
  input  logic pg_en,
  output logic sys_rst,
  output logic pwr_ok
);
  localparam int PCW = $clog2(RST_PULSE + 1);

  logic [PCW-1:0] left_q;
  logic           rsel_q, psel_q;
  logic           active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      rsel_q <= 1'b0;
      psel_q <= 1'b0;
    end else if (fire) begin
      left_q <= PCW'(RST_PULSE);
      rsel_q <= rst_en;
      psel_q <= pg_en;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active  = (left_q != '0);
  assign sys_rst = rsel_q && active;
  assign pwr_ok  = !(psel_q && active);
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
  parameter int CNT_W         = 16,
  parameter int TICKS_PER_MIN = 60,
  parameter int RST_PULSE     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sec_tick,
  input  logic       ir_stb,
  input  logic       mouse_stb,
  input  logic       kbd_stb,
  input  logic       gp_stb,
  output logic       sys_rst_o,
  output logic       pwr_ok_o
);
  logic [CNT_W-1:0] cnt_w, load_val_w;
  logic [3:0]       src_en_w;
  logic             sec_mode_w, rst_en_w, pg_en_w;
  logic             load_w, force_w, status_w;
  logic             act_w, step_w, running_w, expire_w;

  // enable order matches control bits 7..4: ir, mouse, kbd, game
  assign act_w = |(src_en_w & {ir_stb, mouse_stb, kbd_stb, gp_stb});

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cnt(cnt_w), .expire(expire_w),
    .src_en(src_en_w), .sec_mode(sec_mode_w), .rst_en(rst_en_w),
    .pg_en(pg_en_w), .load(load_w), .load_val(load_val_w),
    .force_exp(force_w), .status(status_w)
  );

  wdt_prescale #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .sec_mode(sec_mode_w),
    .restart(load_w || (act_w && running_w)), .step(step_w)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load_w), .load_val(load_val_w),
    .reload(act_w), .step(step_w), .force_exp(force_w),
    .cnt(cnt_w), .running(running_w), .expire(expire_w)
  );

  wdt_pulse #(.RST_PULSE(RST_PULSE)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(expire_w), .rst_en(rst_en_w),
    .pg_en(pg_en_w), .sys_rst(sys_rst_o), .pwr_ok(pwr_ok_o)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W     = 16,
  parameter int RST_PULSE = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             load,
  input logic             activity,
  input logic             step,
  input logic             force_exp,
  input logic             expire,
  input logic             status,
  input logic             sys_rst,
  input logic             pwr_ok
);
  localparam int RW = $clog2(RST_PULSE + 2) + 1;

  logic [RW-1:0] rst_run, pg_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_run <= '0;
      pg_run  <= '0;
    end else begin
      rst_run <= expire ? '0 : (sys_rst ? rst_run + 1'b1 : '0);
      pg_run  <= expire ? '0 : (!pwr_ok ? pg_run + 1'b1 : '0);
    end
  end

  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) && !load |=> (cnt == '0));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) && step && !load && !activity && !force_exp
      |=> (cnt == $past(cnt) - CNT_W'(1)));

  a_r8_rises_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !(activity && (cnt != '0)) |=> (cnt <= $past(cnt)));

  a_r6_status_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status);

  a_r9_force_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    force_exp |=> (cnt == '0));

  a_r6_rst_width: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> (rst_run < RW'(RST_PULSE)));

  a_r7_pg_width: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> (pg_run < RW'(RST_PULSE)));
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W), .RST_PULSE(RST_PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .load(load_w), .activity(act_w),
  .step(step_w), .force_exp(force_w), .expire(expire_w), .status(status_w),
  .sys_rst(sys_rst_o), .pwr_ok(pwr_ok_o)
);

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  localparam int TPM = 4;
  localparam int PUL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
  logic sec_tick = 1'b0, ir_stb = 1'b0, mouse_stb = 1'b0, kbd_stb = 1'b0, gp_stb = 1'b0;
  logic sys_rst_o, pwr_ok_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_top #(.CNT_W(16), .TICKS_PER_MIN(TPM), .RST_PULSE(PUL)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
    .ir_stb(ir_stb), .mouse_stb(mouse_stb), .kbd_stb(kbd_stb), .gp_stb(gp_stb),
    .sys_rst_o(sys_rst_o), .pwr_ok_o(pwr_ok_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk); bus_addr = a; #1; v = int'(bus_rdata);
  endtask

  task automatic rd_cnt(output int v);
    int lo, hi;
    rd(8'h73, lo); rd(8'h74, hi);
    v = hi * 256 + lo;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: ir_stb = 1'b1;
      1: mouse_stb = 1'b1;
      2: kbd_stb = 1'b1;
      default: gp_stb = 1'b1;
    endcase
    @(negedge clk);
    ir_stb = 1'b0; mouse_stb = 1'b0; kbd_stb = 1'b0; gp_stb = 1'b0;
  endtask

  // counts consecutive cycles, from the current falling edge, in which rst (sel=0) or pg drop (sel=1) is active
  task automatic measure(input int sel, output int n, output int other);
    n = 0; other = 0;
    for (int i = 0; i < 12; i++) begin
      if (sel == 0 ? sys_rst_o : !pwr_ok_o) n++;
      if (sel == 0 ? !pwr_ok_o : sys_rst_o) other++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, n, o;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 8'h70; a <= 8'h75; a++) begin
      rd(8'(a), v); check("R1 reset read", v, 0);
    end
    check("R1 reset sys_rst", int'(sys_rst_o), 0);
    check("R1 reset pwr_ok", int'(pwr_ok_o), 1);
    wr(8'h72, 8'h5A); rd(8'h72, v); check("R1 cfg readback", v, 8'h5A);
    wr(8'h72, 8'h00);

    // R2 high byte held, low byte loads
    wr(8'h74, 8'h12); rd_cnt(v); check("R2 high write alone", v, 0);
    wr(8'h73, 8'h34); rd_cnt(v); check("R2 combined load", v, 16'h1234);
    wr(8'h74, 8'h00); rd_cnt(v); check("R2 high hold no change", v, 16'h1234);
    wr(8'h73, 8'h00);

    // R3/R6 seconds sweep with reset enabled
    wr(8'h72, 8'hC0);
    for (int nload = 1; nload <= 6; nload++) begin
      wr(8'h71, 8'h00);
      wr(8'h73, 8'(nload));
      for (int k = 1; k < nload; k++) begin
        tick(); rd_cnt(v); check("R3 seconds step", v, nload - k);
      end
      tick();
      measure(0, n, o);
      check("R6 rst pulse width", n, PUL);
      check("R7 pg untouched", o, 0);
      rd_cnt(v); check("R6 count held zero", v, 0);
      rd(8'h71, v); check("R6 status set", v & 1, 1);
    end

    // R5 stopped
    wr(8'h71, 8'h00);
    for (int k = 0; k < 5; k++) tick();
    rd_cnt(v); check("R5 stopped count", v, 0);
    rd(8'h71, v); check("R5 no expiry", v & 1, 0);
    check("R5 no reset", int'(sys_rst_o), 0);

    // R4/R7 minutes sweep, test mode with pg drop
    wr(8'h72, 8'h10);
    for (int nload = 1; nload <= 3; nload++) begin
      wr(8'h73, 8'(nload));
      for (int k = 1; k < nload * TPM; k++) begin
        tick(); rd_cnt(v);
        check("R4 minutes step", v, nload - k / TPM);
      end
      tick();
      measure(1, n, o);
      check("R7 pg drop width", n, PUL);
      check("R6 test mode no reset", o, 0);
      rd_cnt(v); check("R4 expired zero", v, 0);
    end

    // R8 reload sources, each enabled and disabled
    wr(8'h72, 8'h80);
    for (int s = 0; s < 4; s++) begin
      for (int en = 0; en < 2; en++) begin
        wr(8'h71, en ? 8'(8'h80 >> s) : (8'hF0 & ~8'(8'h80 >> s)));
        wr(8'h73, 8'd5);
        tick(); tick();
        strobe(s);
        rd_cnt(v); check("R8 source reload", v, en ? 5 : 3);
      end
    end
    wr(8'h71, 8'hF0);
    wr(8'h73, 8'd0);
    for (int s = 0; s < 4; s++) strobe(s);
    rd_cnt(v); check("R8 strobe while stopped", v, 0);

    // R4 prescaler restarts on reload
    wr(8'h72, 8'h00);
    wr(8'h71, 8'h10);
    wr(8'h73, 8'd2);
    tick(); tick(); tick();
    rd_cnt(v); check("R4 before reload", v, 2);
    strobe(3);
    tick(); tick(); tick();
    rd_cnt(v); check("R4 prescaler restarted", v, 2);
    tick();
    rd_cnt(v); check("R4 first minute after reload", v, 1);
    wr(8'h73, 8'd0);

    // R9 forced expiry while stopped, reset enabled
    wr(8'h72, 8'h40);
    wr(8'h71, 8'h00);
    wr(8'h71, 8'h02);
    measure(0, n, o);
    check("R9 forced rst width", n, PUL);
    rd(8'h71, v); check("R9 status and bit1 reads 0", v, 1);
    wr(8'h73, 8'd9);
    wr(8'h71, 8'h03);
    rd_cnt(v); check("R9 forced count zero", v, 0);
    measure(0, n, o);

    // R10 status write rules
    wr(8'h71, 8'h01); rd(8'h71, v); check("R10 write 1 keeps set", v, 1);
    wr(8'h71, 8'h00); rd(8'h71, v); check("R10 write 0 clears", v, 0);
    wr(8'h71, 8'h01); rd(8'h71, v); check("R10 write 1 no set", v, 0);
    wr(8'h71, 8'h02); rd(8'h71, v); check("R10 expiry beats clear", v & 1, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule